// File: doc/BRIEF.md
# Program Counter and Stack Unit

This block holds the instruction address register of a small 8-bit controller core together with its byte-wide stack pointer. An instruction decoder, which lives outside this block, drives one command per cycle. The command can advance the program counter by one, apply a signed relative displacement, load an absolute target, call or return from a subroutine, or push or pop a single byte. The pointer and the popped byte are produced here, and the decoder waits on `busy` while a multi-cycle call or return runs.

The stack lives in a byte-wide internal RAM with a synchronous port, so read data appears one clock after the read is issued. The stack grows toward higher addresses. A write goes to the incremented pointer, and a read takes the byte under the current pointer before the pointer drops. A call stores the return address low byte first, which leaves the high byte on top of the stack. A return therefore takes the high byte off first.

Top module: `flow_stack_unit`

## Requirements
- R1: After reset, `pc` is 0x0000, `sp` is 0x07 and `busy` is low.
- R2: Command code 1 (advance), accepted while `busy` is low, makes `pc` one larger after the next clock edge. 0xFFFF wraps to 0x0000.
- R3: Command code 2 (relative) adds `relOffset`, read as two's complement and sign-extended to 16 bits, to `pc` at the next edge. The sum wraps modulo 65536 in both directions.
- R4: Command code 3 (jump) loads `jumpTarget` into `pc` at the next edge.
- R5: Command code 6 (push) writes `pushData` to RAM at address `sp`+1 in the same cycle, and `sp` takes that incremented value at the edge. 0xFF wraps to 0x00.
- R6: Command code 7 (pop) reads RAM at the current `sp`, and `sp` decrements at the edge, with 0x00 wrapping to 0xFF. The byte read shows on `popData` after the following edge.
- R7: Command code 4 (call) takes two cycles. The first cycle writes `pc[7:0]` at `sp`+1. The second cycle holds `busy` high and writes `pc[15:8]` at the next address. At the end `sp` has risen by two and `pc` equals the `jumpTarget` sampled when the call was accepted.
- R8: Command code 5 (return) reads the high byte at `sp` and then the low byte at `sp`-1, lowering `sp` by two. `pc` is loaded from the two bytes at the third edge, and `busy` is high for the two cycles between.
- R9: Any command presented while `busy` is high is ignored. It changes neither `pc` nor `sp`, nor the outcome of the running call or return.
- R10: Command code 0 (none) leaves `pc`, `sp` and the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command code: 0 none, 1 advance, 2 relative, 3 jump, 4 call, 5 return, 6 push, 7 pop |
| relOffset | input | 8 | Signed displacement for a relative branch |
| jumpTarget | input | 16 | Absolute destination for jump and call |
| pushData | input | 8 | Byte stored by a push |
| ramAddr | output | 8 | Stack RAM address |
| ramWe | output | 1 | Stack RAM write enable |
| ramWdata | output | 8 | Stack RAM write data |
| ramRe | output | 1 | Stack RAM read enable |
| ramRdata | input | 8 | Stack RAM read data, valid one cycle after `ramRe` |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| popData | output | 8 | Most recent byte popped |
| busy | output | 1 | High while a call or return occupies the unit |

## Verification
Relative branches are tried with small positive and negative offsets and with the extreme positive offset. They are also applied across the 0x0000/0xFFFF boundary in both directions, which separates true sign extension from zero extension and from carry dropped into a 17th bit. Pushes are checked against the RAM contents at the new pointer, which shows whether the address is taken before or after the increment. Filling the stack up to 0xFF and beyond exercises pointer wrap in both directions. A call followed by a return, with conflicting commands held on the inputs while `busy` is high, checks the byte order on the stack and that commands are ignored while busy.

// File: rtl/flow_stack_pkg.sv
package flow_stack_pkg;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_INC  = 3'd1,
    CMD_REL  = 3'd2,
    CMD_JUMP = 3'd3,
    CMD_CALL = 3'd4,
    CMD_RET  = 3'd5,
    CMD_PUSH = 3'd6,
    CMD_POP  = 3'd7
  } flowCmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALL_HI,
    ST_RET_LO,
    ST_RET_FIN
  } flowState_e;

  typedef enum logic [1:0] {
    WR_DATA,
    WR_PC_LO,
    WR_PC_HI
  } wrSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic   pcInc;
    logic   pcRel;
    logic   pcJump;
    logic   pcFromHold;
    logic   pcFromStack;
    logic   holdTarget;
    logic   spUp;
    logic   spDown;
    logic   memWrite;
    logic   memRead;
    wrSel_e wrSel;
    logic   grabHigh;
    logic   grabPop;
  } flowStrobe_t;

endpackage

// File: rtl/flow_stack_ctrl.sv
module flow_stack_ctrl
  import flow_stack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  cmd,
  output flowStrobe_t stb,
  output logic        busy
);

  flowState_e stateQ, stateN;
  logic       popPendQ, popPendN;
  flowCmd_e   cmdE;

  assign cmdE = flowCmd_e'(cmd);
  assign busy = (stateQ != ST_IDLE);

  always_comb begin
    stb         = '0;
    stb.wrSel   = WR_DATA;
    stateN      = stateQ;
    popPendN    = 1'b0;
    stb.grabPop = popPendQ;
    unique case (stateQ)
      ST_IDLE: begin
        unique case (cmdE)
          CMD_INC:  stb.pcInc  = 1'b1;
          CMD_REL:  stb.pcRel  = 1'b1;
          CMD_JUMP: stb.pcJump = 1'b1;
          CMD_PUSH: begin
            stb.spUp     = 1'b1;
            stb.memWrite = 1'b1;
            stb.wrSel    = WR_DATA;
          end
          CMD_POP: begin
            stb.memRead = 1'b1;
            stb.spDown  = 1'b1;
            popPendN    = 1'b1;
          end
          CMD_CALL: begin
            stb.spUp       = 1'b1;
            stb.memWrite   = 1'b1;
            stb.wrSel      = WR_PC_LO;
            stb.holdTarget = 1'b1;
            stateN         = ST_CALL_HI;
          end
          CMD_RET: begin
            stb.memRead = 1'b1;
            stb.spDown  = 1'b1;
            stateN      = ST_RET_LO;
          end
          default: ;
        endcase
      end
      ST_CALL_HI: begin
        stb.spUp       = 1'b1;
        stb.memWrite   = 1'b1;
        stb.wrSel      = WR_PC_HI;
        stb.pcFromHold = 1'b1;
        stateN         = ST_IDLE;
      end
      ST_RET_LO: begin
        stb.memRead  = 1'b1;
        stb.spDown   = 1'b1;
        stb.grabHigh = 1'b1;
        stateN       = ST_RET_FIN;
      end
      ST_RET_FIN: begin
        stb.pcFromStack = 1'b1;
        stateN          = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      popPendQ <= 1'b0;
    end else begin
      stateQ   <= stateN;
      popPendQ <= popPendN;
    end
  end

  // R7: the second call cycle always ends the call
  p_call_two_cycles_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_CALL_HI) |=> (stateQ == ST_IDLE));

  // R8: return walks both read cycles then the load cycle
  p_ret_sequence_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RET_LO) |=> (stateQ == ST_RET_FIN));

  p_ret_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RET_FIN) |=> !busy);

endmodule

// File: rtl/flow_stack_dp.sv
module flow_stack_dp
  import flow_stack_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SP_W     = 8,
  parameter int SP_RESET = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flowStrobe_t          stb,
  input  logic [BYTE_W-1:0]    relOffset,
  input  logic [2*BYTE_W-1:0]  jumpTarget,
  input  logic [BYTE_W-1:0]    pushData,
  input  logic [BYTE_W-1:0]    ramRdata,
  output logic [SP_W-1:0]      ramAddr,
  output logic                 ramWe,
  output logic [BYTE_W-1:0]    ramWdata,
  output logic                 ramRe,
  output logic [2*BYTE_W-1:0]  pc,
  output logic [SP_W-1:0]      sp,
  output logic [BYTE_W-1:0]    popData
);

  localparam int PC_W  = 2 * BYTE_W;
  localparam int EXT_W = PC_W - BYTE_W;

  logic [PC_W-1:0]   pcQ, targetQ, offExt;
  logic [SP_W-1:0]   spQ, spUpV, spDownV;
  logic [BYTE_W-1:0] hiQ, popQ;

  assign offExt  = {{EXT_W{relOffset[BYTE_W-1]}}, relOffset};
  assign spUpV   = spQ + SP_W'(1);
  assign spDownV = spQ - SP_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (stb.pcInc) begin
      pcQ <= pcQ + PC_W'(1);
    end else if (stb.pcRel) begin
      pcQ <= pcQ + offExt;
    end else if (stb.pcJump) begin
      pcQ <= jumpTarget;
    end else if (stb.pcFromHold) begin
      pcQ <= targetQ;
    end else if (stb.pcFromStack) begin
      pcQ <= {hiQ, ramRdata};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ     <= SP_W'(SP_RESET);
      targetQ <= '0;
      hiQ     <= '0;
      popQ    <= '0;
    end else begin
      if (stb.spUp)            spQ <= spUpV;
      else if (stb.spDown)     spQ <= spDownV;
      if (stb.holdTarget)      targetQ <= jumpTarget;
      if (stb.grabHigh)        hiQ <= ramRdata;
      if (stb.grabPop)         popQ <= ramRdata;
    end
  end

  // a write goes to the incremented pointer, a read to the current one
  assign ramAddr = stb.spUp ? spUpV : spQ;
  assign ramWe   = stb.memWrite;
  assign ramRe   = stb.memRead;

  always_comb begin
    unique case (stb.wrSel)
      WR_PC_LO: ramWdata = pcQ[BYTE_W-1:0];
      WR_PC_HI: ramWdata = pcQ[PC_W-1:BYTE_W];
      default:  ramWdata = pushData;
    endcase
  end

  assign pc      = pcQ;
  assign sp      = spQ;
  assign popData = popQ;

  // R5: after a write the pointer sits on the address just written
  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> (sp == $past(ramAddr)));

  // R6: a read takes the byte under the pointer, which then drops by one
  p_pop_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> (sp == SP_W'($past(ramAddr) - SP_W'(1))));

  p_port_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && ramRe));

endmodule

// File: rtl/flow_stack_unit.sv
module flow_stack_unit
  import flow_stack_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SP_W     = 8,
  parameter int SP_RESET = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          cmd,
  input  logic [BYTE_W-1:0]   relOffset,
  input  logic [2*BYTE_W-1:0] jumpTarget,
  input  logic [BYTE_W-1:0]   pushData,
  output logic [SP_W-1:0]     ramAddr,
  output logic                ramWe,
  output logic [BYTE_W-1:0]   ramWdata,
  output logic                ramRe,
  input  logic [BYTE_W-1:0]   ramRdata,
  output logic [2*BYTE_W-1:0] pc,
  output logic [SP_W-1:0]     sp,
  output logic [BYTE_W-1:0]   popData,
  output logic                busy
);

  localparam int PC_W = 2 * BYTE_W;

  flowStrobe_t stb;

  flow_stack_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .stb  (stb),
    .busy (busy)
  );

  flow_stack_dp #(
    .BYTE_W   (BYTE_W),
    .SP_W     (SP_W),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .relOffset  (relOffset),
    .jumpTarget (jumpTarget),
    .pushData   (pushData),
    .ramRdata   (ramRdata),
    .ramAddr    (ramAddr),
    .ramWe      (ramWe),
    .ramWdata   (ramWdata),
    .ramRe      (ramRe),
    .pc         (pc),
    .sp         (sp),
    .popData    (popData)
  );

  // R3: relative branch lands on the sign-extended sum
  p_rel_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmd == CMD_REL) |=>
      (pc == PC_W'($past(pc) + {{(PC_W-BYTE_W){$past(relOffset[BYTE_W-1])}}, $past(relOffset)})));

  // R7: an accepted call raises busy and moves the pointer up by one
  p_call_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmd == CMD_CALL) |=> (busy && sp == SP_W'($past(sp) + SP_W'(1))));

  // R10: the empty command holds the visible state
  p_none_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmd == CMD_NONE) |=> ($stable(pc) && $stable(sp)));

  // R9: while a return reads the stack the program counter does not move
  p_busy_pc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ramRe) |=> $stable(pc));

endmodule

// File: tb/flow_stack_unit_tb.sv
module flow_stack_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [7:0]  relOffset = 8'h00;
  logic [15:0] jumpTarget = 16'h0000;
  logic [7:0]  pushData = 8'h00;
  logic [7:0]  ramAddr;
  logic        ramWe;
  logic [7:0]  ramWdata;
  logic        ramRe;
  logic [7:0]  ramRdata = 8'h00;
  logic [15:0] pc;
  logic [7:0]  sp;
  logic [7:0]  popData;
  logic        busy;

  logic [7:0] mem [256];

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flow_stack_unit u_dut (
    .clk (clk), .rstN (rstN), .cmd (cmd), .relOffset (relOffset),
    .jumpTarget (jumpTarget), .pushData (pushData), .ramAddr (ramAddr),
    .ramWe (ramWe), .ramWdata (ramWdata), .ramRe (ramRe), .ramRdata (ramRdata),
    .pc (pc), .sp (sp), .popData (popData), .busy (busy)
  );

  // synchronous RAM model: read data one cycle after the read
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  // vector: cmd, offset, target, push byte, expected pc, expected sp
  localparam logic [58:0] VEC [NVEC] = '{
    {3'd1, 8'h00, 16'h0000, 8'h00, 16'h0001, 8'h07},  // R2 advance
    {3'd2, 8'h10, 16'h0000, 8'h00, 16'h0011, 8'h07},  // R3 forward
    {3'd2, 8'hF0, 16'h0000, 8'h00, 16'h0001, 8'h07},  // R3 backward
    {3'd3, 8'h00, 16'hFFFE, 8'h00, 16'hFFFE, 8'h07},  // R4 jump
    {3'd1, 8'h00, 16'h0000, 8'h00, 16'hFFFF, 8'h07},  // R2
    {3'd1, 8'h00, 16'h0000, 8'h00, 16'h0000, 8'h07},  // R2 wrap
    {3'd2, 8'hFE, 16'h0000, 8'h00, 16'hFFFE, 8'h07},  // R3 wrap down
    {3'd2, 8'h7F, 16'h0000, 8'h00, 16'h007D, 8'h07},  // R3 wrap up
    {3'd6, 8'h00, 16'h0000, 8'hA5, 16'h007D, 8'h08},  // R5 push
    {3'd6, 8'h00, 16'h0000, 8'h3C, 16'h007D, 8'h09},  // R5 push
    {3'd0, 8'h55, 16'hBEEF, 8'h99, 16'h007D, 8'h09},  // R10 none
    {3'd7, 8'h00, 16'h0000, 8'h00, 16'h007D, 8'h08},  // R6 pop
    {3'd3, 8'h00, 16'h1234, 8'h00, 16'h1234, 8'h08}   // R4 jump
  };

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    tick;
    tick;
    rstN = 1'b1;
    #1;
    chk("R1 pc", 32'(pc), 32'h0000);
    chk("R1 sp", 32'(sp), 32'h07);
    chk("R1 busy", 32'(busy), 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      {cmd, relOffset, jumpTarget, pushData} = VEC[v][58:24];
      tick;
      chk($sformatf("R2-vector %0d pc", v), 32'(pc), 32'(VEC[v][23:8]));
      chk($sformatf("R5-vector %0d sp", v), 32'(sp), 32'(VEC[v][7:0]));
    end
    cmd = 3'd0;

    chk("R5 byte at new pointer", 32'(mem[8]), 32'hA5);
    chk("R5 second byte", 32'(mem[9]), 32'h3C);
    chk("R6 popped byte", 32'(popData), 32'h3C);
    chk("R10 no write on none", 32'(mem[10]), 32'h00);

    // R7 call from pc 0x1234, sp 0x08
    cmd = 3'd4; jumpTarget = 16'hABCD;
    tick;
    chk("R7 busy in second cycle", 32'(busy), 32'h1);
    chk("R7 sp after first", 32'(sp), 32'h09);
    chk("R7 low byte first", 32'(mem[9]), 32'h34);
    cmd = 3'd3; jumpTarget = 16'h5555;   // R9 ignored while busy
    tick;
    cmd = 3'd0;
    chk("R7 pc target", 32'(pc), 32'hABCD);
    chk("R7 sp final", 32'(sp), 32'h0A);
    chk("R7 high byte on top", 32'(mem[10]), 32'h12);
    chk("R7 busy cleared", 32'(busy), 32'h0);
    chk("R9 call unaffected", 32'(pc), 32'hABCD);

    // R8 return
    cmd = 3'd5;
    tick;
    cmd = 3'd1;                          // R9 ignored while busy
    chk("R8 busy after accept", 32'(busy), 32'h1);
    chk("R8 sp after first read", 32'(sp), 32'h09);
    tick;
    chk("R8 busy second", 32'(busy), 32'h1);
    chk("R8 sp after second read", 32'(sp), 32'h08);
    chk("R9 pc held while busy", 32'(pc), 32'hABCD);
    tick;
    cmd = 3'd0;
    chk("R8 pc restored", 32'(pc), 32'h1234);
    chk("R8 busy cleared", 32'(busy), 32'h0);
    chk("R9 sp unaffected", 32'(sp), 32'h08);

    // R5/R6 pointer wrap
    for (int i = 0; i < 247; i++) begin
      cmd = 3'd6; pushData = 8'(i);
      tick;
    end
    chk("R5 sp at top", 32'(sp), 32'hFF);
    pushData = 8'h5A;
    tick;
    cmd = 3'd0;
    chk("R5 sp wraps up", 32'(sp), 32'h00);
    chk("R5 byte at 0x00", 32'(mem[0]), 32'h5A);
    cmd = 3'd7;
    tick;
    cmd = 3'd0;
    chk("R6 sp wraps down", 32'(sp), 32'hFF);
    tick;
    chk("R6 popped after wrap", 32'(popData), 32'h5A);
    chk("R10 pc untouched by stack ops", 32'(pc), 32'h1234);

    finish_run();
  end

endmodule